// File: doc/BRIEF.md
# Reversible-Gate One-Hot Decoder

This block turns a small binary select word into a one-hot vector of 2^SEL_W lines. It is built entirely from bit-conserving gates: an inverter, a controlled-NOT, a Peres gate, a TR gate and a Fredkin (controlled-swap) gate. Each gate has as many outputs as inputs. No wire drives more than one gate input. Where a bit is needed twice, a controlled-NOT with a zero target copies it. Every constant input is a zero tied inside the module that uses it, and every gate output that the decode does not use leaves the block on a garbage bus.

The 2:4 core takes the two most significant select bits. It uses one Peres gate, one TR gate, one inverter and three controlled-NOTs, and the cost figures of those gates add up to 11. Each further select bit adds one expansion stage. In that stage, one Fredkin gate per incoming minterm line takes the select bit as its control and a tied zero as its second data input. The gate then returns both the "bit low" product and the "bit high" product. The control passes from gate to gate through the stage, so it is never fanned out. SEL_W may be 2, 3 or 4. At 4 the netlist holds 18 gates: 12 Fredkin, 1 Peres, 1 TR, 1 inverter and 3 controlled-NOT.

The block has no clock and no state. It is used wherever a select code must be expanded into enables inside a design that keeps to reversible construction.

Top module: `rvdec_onehot`

## Requirements
- R1: For every select code, exactly one bit of `onehot` is 1.
- R2: Bit i of `onehot` is 1 exactly when `sel` equals i, with `sel[SEL_W-1]` as the most significant bit.
- R3: The controlled-NOT maps (a,b) to (a, a XOR b) and is a bijection on its 2-bit vector.
- R4: The Peres gate maps (a,b,c) to (a, a XOR b, (a AND b) XOR c) and is a bijection on its 3-bit vector.
- R5: The TR gate maps (a,b,c) to (a, a XOR b, (a AND NOT b) XOR c) and is a bijection on its 3-bit vector.
- R6: The Fredkin gate maps (a,b,c) to (a, b, c) when a=0 and to (a, c, b) when a=1, and is a bijection on its 3-bit vector.
- R7: The inverter maps a to NOT a and is a bijection on one bit.
- R8: `garbage` is SEL_W-1 bits wide. Bit 0 carries `sel[SEL_W-1]` out of the 2:4 core's TR gate. Bit k (k >= 1) carries the control that leaves expansion stage k, which equals `sel[SEL_W-2-k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel | input | SEL_W | Binary select code, MSB first |
| onehot | output | 2^SEL_W | One-hot decode of `sel` |
| garbage | output | SEL_W-1 | Unused gate outputs: the core pass-through and one control line per stage |

## Verification
The hardest part to reach from the ports is whether each gate is a bijection. Inside the decoder, every constant input is tied to zero, so half of each gate's input space never occurs. A mapping error on those codes would never show on `onehot`. The bench therefore instantiates each gate on its own and sweeps its whole input vector, including the codes with a 1 on the constant line. It also records every output pattern it sees, so that any repeated pattern shows up. The decoder is then swept over every code at SEL_W of 2, 3 and 4, with the expected one-hot word and garbage bits computed by shifting and bit selection.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;
    // Number of select bits consumed by the 2:4 core.
    localparam int unsigned CORE_SEL_W = 2;
    localparam int unsigned CORE_OUT_W = 1 << CORE_SEL_W;

    // Select bit that feeds expansion stage s (s >= 1).
    function automatic int unsigned stage_sel_bit(input int unsigned sel_w, input int unsigned s);
        return sel_w - 2 - s;
    endfunction

    // Bit offset of level s inside the concatenated minterm chain.
    function automatic int unsigned level_offset(input int unsigned s);
        return (CORE_OUT_W << s) - CORE_OUT_W;
    endfunction
endpackage

// File: rtl/rv_gates.sv
// 1x1 inverter, cost 0.
module rv_not (
    input  logic a,
    output logic y
);
    assign y = ~a;
endmodule

// 2x2 controlled-NOT, cost 1; with b tied to 0 it copies a.
module rv_cnot (
    input  logic a,
    input  logic b,
    output logic p,
    output logic q
);
    assign p = a;
    assign q = a ^ b;
endmodule

// 3x3 Peres gate, cost 4.
module rv_peres (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic q,
    output logic r
);
    assign p = a;
    assign q = a ^ b;
    assign r = (a & b) ^ c;
endmodule

// 3x3 TR gate, cost 4.
module rv_tr (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic q,
    output logic r
);
    assign p = a;
    assign q = a ^ b;
    assign r = (a & ~b) ^ c;
endmodule

// 3x3 Fredkin gate (controlled swap of b and c), cost 5.
module rv_fredkin (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic q,
    output logic r
);
    assign p = a;
    assign q = (~a & b) | (a & c);
    assign r = (~a & c) | (a & b);
endmodule

// File: rtl/rv_dec2.sv
// 2:4 core: Peres + TR + NOT + 3 CNOT, total cost 11.
module rv_dec2 (
    input  logic       x,       // MSB
    input  logic       y,       // LSB
    output logic [3:0] m,       // m[i] = (x,y) == i
    output logic       g        // garbage: x passed through the TR gate
);
    logic y_a, y_b;
    logic x_fwd, xor_p, and_xy;
    logic xor_t, x_not_y;
    logic xnor_p;

    // Copy y so that the Peres and TR gates each get their own line.
    rv_cnot u_dup_y (.a(y), .b(1'b0), .p(y_a), .q(y_b));

    // Peres: x^y and x&y.
    rv_peres u_pg (.a(x), .b(y_a), .c(1'b0), .p(x_fwd), .q(xor_p), .r(and_xy));

    // TR: x^y and x&~y; x travels on from the Peres gate, not by fan-out.
    rv_tr u_trg (.a(x_fwd), .b(y_b), .c(1'b0), .p(g), .q(xor_t), .r(x_not_y));

    // Invert the Peres XOR term: xy + x'y'.
    rv_not u_inv (.a(xor_p), .y(xnor_p));

    // (x^y) ^ xy' = x'y
    rv_cnot u_mix_lo (.a(x_not_y), .b(xor_t), .p(m[2]), .q(m[1]));
    // (xy + x'y') ^ xy = x'y'
    rv_cnot u_mix_hi (.a(and_xy), .b(xnor_p), .p(m[3]), .q(m[0]));
endmodule

// File: rtl/rv_fredkin_stage.sv
// One expansion stage: doubles the minterm count with one Fredkin per line.
module rv_fredkin_stage #(
    parameter  int unsigned IN_W  = 4,
    localparam int unsigned OUT_W = 2 * IN_W
) (
    input  logic             ctrl,      // new select bit (next lower weight)
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout,
    output logic             ctrl_out   // control after the last gate (garbage)
);
    logic [IN_W:0] c_chain;
    assign c_chain[0] = ctrl;

    for (genvar i = 0; i < IN_W; i++) begin : g_cell
        // b = minterm, c = tied 0: q = ctrl' * din, r = ctrl * din
        rv_fredkin u_fg (
            .a (c_chain[i]),
            .b (din[i]),
            .c (1'b0),
            .p (c_chain[i+1]),
            .q (dout[2*i]),
            .r (dout[2*i+1])
        );
    end

    assign ctrl_out = c_chain[IN_W];
endmodule

// File: rtl/rvdec_onehot.sv
module rvdec_onehot
    import rvdec_pkg::*;
#(
    parameter  int unsigned SEL_W  = 4,
    localparam int unsigned OUT_W  = 1 << SEL_W,
    localparam int unsigned GARB_W = SEL_W - 1,
    localparam int unsigned CHAIN_W = 2 * OUT_W - CORE_OUT_W
) (
    input  logic [SEL_W-1:0]  sel,
    output logic [OUT_W-1:0]  onehot,
    output logic [GARB_W-1:0] garbage
);
    // Level s of the minterm tree lives at chain[level_offset(s) +: 4<<s].
    logic [CHAIN_W-1:0] chain;

    rv_dec2 u_core (
        .x (sel[SEL_W-1]),
        .y (sel[SEL_W-2]),
        .m (chain[CORE_OUT_W-1:0]),
        .g (garbage[0])
    );

    for (genvar s = 1; s <= SEL_W - CORE_SEL_W; s++) begin : g_stage
        localparam int unsigned IW = CORE_OUT_W << (s - 1);
        rv_fredkin_stage #(.IN_W(IW)) u_stg (
            .ctrl     (sel[stage_sel_bit(SEL_W, s)]),
            .din      (chain[level_offset(s-1) +: IW]),
            .dout     (chain[level_offset(s) +: 2*IW]),
            .ctrl_out (garbage[s])
        );
    end

    assign onehot = chain[level_offset(SEL_W - CORE_SEL_W) +: OUT_W];
endmodule

// File: rtl/rvdec_onehot_chk.sv
module rvdec_onehot_chk #(
    parameter  int unsigned SEL_W  = 4,
    localparam int unsigned OUT_W  = 1 << SEL_W,
    localparam int unsigned GARB_W = SEL_W - 1
) (
    input logic [SEL_W-1:0]  sel,
    input logic [OUT_W-1:0]  onehot,
    input logic [GARB_W-1:0] garbage
);
    always_comb begin
        if (!$isunknown(sel)) begin
            assert_single_hot_R1: assert ($countones(onehot) == 1)
                else $error("R1: onehot=%b not one-hot", onehot);
            assert_index_hot_R2: assert (onehot[sel] == 1'b1)
                else $error("R2: sel=%0d onehot=%b", sel, onehot);
            assert_core_garbage_R8: assert (garbage[0] == sel[SEL_W-1])
                else $error("R8: core garbage %b sel=%b", garbage[0], sel);
            for (int k = 1; k < int'(GARB_W); k++) begin
                assert_stage_garbage_R8: assert (garbage[k] == sel[SEL_W-2-k])
                    else $error("R8: stage %0d garbage %b sel=%b", k, garbage[k], sel);
            end
        end
    end
endmodule

bind rvdec_onehot rvdec_onehot_chk #(.SEL_W(SEL_W)) u_chk (
    .sel     (sel),
    .onehot  (onehot),
    .garbage (garbage)
);

// File: tb/rvdec_onehot_test.sv
module rvdec_onehot_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Gate stimulus
    logic ga, gb, gc;
    logic not_y;
    logic cn_p, cn_q;
    logic pg_p, pg_q, pg_r;
    logic tr_p, tr_q, tr_r;
    logic fg_p, fg_q, fg_r;

    rv_not     u_not (.a(ga), .y(not_y));
    rv_cnot    u_cn  (.a(ga), .b(gb), .p(cn_p), .q(cn_q));
    rv_peres   u_pg  (.a(ga), .b(gb), .c(gc), .p(pg_p), .q(pg_q), .r(pg_r));
    rv_tr      u_tr  (.a(ga), .b(gb), .c(gc), .p(tr_p), .q(tr_q), .r(tr_r));
    rv_fredkin u_fg  (.a(ga), .b(gb), .c(gc), .p(fg_p), .q(fg_q), .r(fg_r));

    // Decoders at the three supported widths
    logic [3:0]  s4;
    logic [2:0]  s3;
    logic [1:0]  s2;
    logic [15:0] oh4;
    logic [7:0]  oh3;
    logic [3:0]  oh2;
    logic [2:0]  gb4;
    logic [1:0]  gb3;
    logic [0:0]  gb2;

    rvdec_onehot #(.SEL_W(4)) uut  (.sel(s4), .onehot(oh4), .garbage(gb4));
    rvdec_onehot #(.SEL_W(3)) uut3 (.sel(s3), .onehot(oh3), .garbage(gb3));
    rvdec_onehot #(.SEL_W(2)) uut2 (.sel(s2), .onehot(oh2), .garbage(gb2));

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0] seen_not;
        logic [3:0] seen_cn;
        logic [7:0] seen_pg, seen_tr, seen_fg;
        seen_not = '0; seen_cn = '0; seen_pg = '0; seen_tr = '0; seen_fg = '0;
        ga = 0; gb = 0; gc = 0;
        s4 = 0; s3 = 0; s2 = 0;

        // Code 0 on all decoders first: the settled starting state.
        @(negedge clk);
        check(oh4 == 16'h0001, "R2 sel=0 width4", oh4, 16'h0001);
        check(gb4 == 3'b000,   "R8 sel=0 width4", gb4, 3'b000);

        // Gate sweeps, every input code including a 1 on constant lines.
        for (int code = 0; code < 8; code++) begin
            logic a, b, c;
            logic [2:0] e_pg, e_tr, e_fg, o;
            {a, b, c} = code[2:0];
            ga = a; gb = b; gc = c;
            @(posedge clk);
            @(negedge clk);
            e_pg = {a, a ^ b, (a & b) ^ c};
            o = {pg_p, pg_q, pg_r};
            check(o == e_pg, "R4 Peres map", o, e_pg);
            check(!seen_pg[o], "R4 Peres bijection", o, code);
            seen_pg[o] = 1'b1;

            e_tr = {a, a ^ b, (a & ~b) ^ c};
            o = {tr_p, tr_q, tr_r};
            check(o == e_tr, "R5 TR map", o, e_tr);
            check(!seen_tr[o], "R5 TR bijection", o, code);
            seen_tr[o] = 1'b1;

            e_fg = a ? {a, c, b} : {a, b, c};
            o = {fg_p, fg_q, fg_r};
            check(o == e_fg, "R6 Fredkin map", o, e_fg);
            check(!seen_fg[o], "R6 Fredkin bijection", o, code);
            seen_fg[o] = 1'b1;

            if (c == 1'b0) begin
                check({cn_p, cn_q} == {a, a ^ b}, "R3 CNOT map", {cn_p, cn_q}, {a, a ^ b});
                check(!seen_cn[{cn_p, cn_q}], "R3 CNOT bijection", {cn_p, cn_q}, code);
                seen_cn[{cn_p, cn_q}] = 1'b1;
            end
            if (b == 1'b0 && c == 1'b0) begin
                check(not_y == ~a, "R7 NOT map", not_y, ~a);
                check(!seen_not[not_y], "R7 NOT bijection", not_y, a);
                seen_not[not_y] = 1'b1;
            end
        end
        check(&seen_pg,  "R4 all Peres outputs reached",   seen_pg,  8'hff);
        check(&seen_tr,  "R5 all TR outputs reached",      seen_tr,  8'hff);
        check(&seen_fg,  "R6 all Fredkin outputs reached", seen_fg,  8'hff);
        check(&seen_cn,  "R3 all CNOT outputs reached",    seen_cn,  4'hf);
        check(&seen_not, "R7 both NOT outputs reached",    seen_not, 2'h3);

        // Decoder sweeps at widths 4, 3 and 2.
        for (int code = 0; code < 16; code++) begin
            logic [3:0] v;
            v = code[3:0];
            s4 = v; s3 = v[2:0]; s2 = v[1:0];
            @(posedge clk);
            @(negedge clk);
            check($countones(oh4) == 1, "R1 width4 single hot", oh4, 16'd1 << v);
            check(oh4 == (16'd1 << v),      "R2 width4 index", oh4, 16'd1 << v);
            check(oh3 == (8'd1 << v[2:0]),  "R2 width3 index", oh3, 8'd1 << v[2:0]);
            check(oh2 == (4'd1 << v[1:0]),  "R2 width2 index", oh2, 4'd1 << v[1:0]);
            check($countones(oh3) == 1 && $countones(oh2) == 1, "R1 width3/2 single hot",
                  {oh3, oh2}, {8'd1 << v[2:0], 4'd1 << v[1:0]});
            check(gb4 == {v[0], v[1], v[3]}, "R8 width4 garbage", gb4, {v[0], v[1], v[3]});
            check(gb3 == {v[0], v[2]},       "R8 width3 garbage", gb3, {v[0], v[2]});
            check(gb2 == v[1],               "R8 width2 garbage", gb2, v[1]);
        end

        // Boundary: all-ones select hits the top line only.
        s4 = 4'hf; s3 = 3'h7; s2 = 2'h3;
        @(posedge clk);
        @(negedge clk);
        check(oh4 == 16'h8000 && oh3 == 8'h80 && oh2 == 4'h8, "R2 all-ones select",
              {oh4, oh3, oh2}, {16'h8000, 8'h80, 4'h8});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule